// File: doc/BRIEF.md
# Serial Index-Register Configuration Master

This block configures an external transceiver module over a slow two-wire serial link. The master drives a clock line and a data line, and it watches two inputs from the module: a response data bit and an active-low read-valid flag. A host asks for one of three operations. A write puts one byte into a module register. A read fetches one byte from a module register. A reset sends a long burst of clock pulses that returns the module's serial port to a known state.

Each access starts with a command byte. Bit 0 of that byte gives the direction, and the address and the left-shifted index are ORed over it. Every byte goes out least significant bit first, after a start pulse with data high. The data line changes only while the clock is low. On a read, the master polls the valid flag with clock pulses, takes eight response bits if the flag falls, and always closes with a fixed trailer. All clock phases are timed by a prescaled counter: a short step sets each high phase and each poll or reset low phase, and a long step sets every other low phase.

The controller has nineteen named states. ST_IDLE waits for a request. A write or read goes to ST_START_LO and ST_START_HI (the start marker), then ST_BIT_LO and ST_BIT_HI for each bit. After the command byte, a write loops back to the start marker for the data byte, then runs ST_TRAIL_LO and ST_TRAIL_HI twice and goes to ST_FINISH. After the command byte, a read goes to ST_GAP_LO, then alternates ST_POLL_HI and ST_POLL_LO. Valid low sends it to ST_RDAT_HI and ST_RDAT_LO, eight times. Ten polls without valid send it to ST_FILL_HI and ST_FILL_LO, twice. Both read paths then run ST_TAIL_HI and ST_TAIL_LO four times and go to ST_FINISH. A reset runs ST_RST_HI and ST_RST_LO thirty times and goes to ST_FINISH. ST_FINISH returns to ST_IDLE after one cycle.

Top module: `xcvr_cfg_master`

## Requirements
- R1: The command byte equals {0,addr} OR {index,0} OR dir, where dir (bit 0) is 1 for a write (req_op 2'b00) and 0 for a read (req_op 2'b01).
- R2: Each byte is preceded by one start clock pulse with data high and is then sent least significant bit first. The data line never changes while the clock stays high.
- R3: A write produces exactly 20 rising clock edges: start, 8 command bits, start, 8 data bits, then 2 pulses with data low. The clock ends low.
- R4: After the read command, the master gives up to 10 poll pulses with data high. It stops after the first poll whose low phase samples the synchronised valid input low.
- R5: When valid is seen, eight bits are sampled at the end of the low phase after each of eight further pulses. They are assembled LSB first into rd_data, and rd_seen is 1.
- R6: When valid stays high through all 10 polls, two extra pulses with data high follow. rd_data is 0 and rd_seen is 0.
- R7: Every read ends with one pulse with data high, followed by three pulses with data low. A read therefore has 21+k rising edges when valid falls at poll k, and 25 when it never falls.
- R8: A reset request (req_op 2'b10) gives exactly 30 clock pulses with data low, and the clock ends low.
- R9: busy is high from the cycle after a request is accepted until done. done is a single-cycle pulse. rd_data and rd_seen are valid while done is high. After reset, and whenever busy is low, the clock and data lines are low.
- R10: A request that arrives while busy, or one with the unused op code 2'b11, is ignored: it produces no clock edges and no extra done pulse.
- R11: The clock high time is SHORT_TICKS*PRESCALE cycles. The low phase before each transmitted bit lasts LONG_TICKS*PRESCALE cycles (8 and 20 with the defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only in idle |
| req_op | input | 2 | 00 write, 01 read, 10 reset, 11 ignored |
| req_addr | input | 7 | Register address field |
| req_index | input | 7 | Index field, ORed in one place left |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Read result (0 when valid never came) |
| rd_seen | output | 1 | Valid was seen on the last read |
| sclk_o | output | 1 | Serial clock to the module |
| sdata_o | output | 1 | Serial data to the module |
| ack_n_i | input | 1 | Active-low read-valid from the module |
| rx_i | input | 1 | Response data bit from the module |

## Verification
The bench rebuilds every frame from the data seen at each rising clock edge. This catches a command byte packed in the wrong bit order, or a design that shifts MSB first and so mirrors every byte. Reads are run with valid falling at poll 1, poll 3 and poll 10, the last allowed poll, and with valid never falling. An off-by-one poll limit would then either take data after a timeout or miss a late valid, and a missing fill pair would give 23 edges instead of 25. A late request and an unused op code are sent to check that neither restarts a frame nor adds a done pulse. The high and low phase widths are measured so that swapped short and long steps are caught.

// File: rtl/xcvr_cfg_pkg.sv
package xcvr_cfg_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_READ  = 2'b01,
        OP_RESET = 2'b10,
        OP_NONE  = 2'b11
    } op_e;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_START_LO,
        ST_START_HI,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_TRAIL_LO,
        ST_TRAIL_HI,
        ST_GAP_LO,
        ST_POLL_HI,
        ST_POLL_LO,
        ST_RDAT_HI,
        ST_RDAT_LO,
        ST_FILL_HI,
        ST_FILL_LO,
        ST_TAIL_HI,
        ST_TAIL_LO,
        ST_RST_HI,
        ST_RST_LO,
        ST_FINISH
    } state_e;

    // direction bit: 1 = write, 0 = read
    function automatic logic [7:0] build_cmd(input logic [6:0] addr,
                                             input logic [6:0] idx,
                                             input logic       wr);
        return {1'b0, addr} | {idx, 1'b0} | {7'd0, wr};
    endfunction

endpackage

// File: rtl/pace_timer.sv
module pace_timer #(
    parameter int SHORT_CYC = 8,
    parameter int LONG_CYC  = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sel_long,
    output logic expired
);
    localparam int TW = $clog2(LONG_CYC + 1);
    localparam logic [TW-1:0] SHORT_LD = TW'(SHORT_CYC - 1);
    localparam logic [TW-1:0] LONG_LD  = TW'(LONG_CYC - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= sel_long ? LONG_LD : SHORT_LD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/in_sync.sv
module in_sync #(
    parameter int   WIDTH   = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= {WIDTH{RST_VAL}};
            q    <= {WIDTH{RST_VAL}};
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/xcvr_cfg_master.sv
module xcvr_cfg_master
    import xcvr_cfg_pkg::*;
#(
    parameter int PRESCALE     = 4,
    parameter int SHORT_TICKS  = 2,
    parameter int LONG_TICKS   = 5,
    parameter int POLL_MAX     = 10,
    parameter int RESET_PULSES = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic [6:0] req_addr,
    input  logic [6:0] req_index,
    input  logic [7:0] req_wdata,
    output logic       busy,
    output logic       done,
    output logic [7:0] rd_data,
    output logic       rd_seen,
    output logic       sclk_o,
    output logic       sdata_o,
    input  logic       ack_n_i,
    input  logic       rx_i
);
    localparam int SHORT_CYC = SHORT_TICKS * PRESCALE;
    localparam int LONG_CYC  = LONG_TICKS * PRESCALE;
    localparam int MAXC      = (RESET_PULSES > POLL_MAX) ?
                               ((RESET_PULSES > 8) ? RESET_PULSES : 8) :
                               ((POLL_MAX > 8) ? POLL_MAX : 8);
    localparam int CW        = $clog2(MAXC + 1);
    localparam logic [CW-1:0] POLL_LAST = CW'(POLL_MAX - 1);
    localparam logic [CW-1:0] RST_LAST  = CW'(RESET_PULSES - 1);
    localparam logic [CW-1:0] BYTE_LAST = CW'(7);
    localparam logic [CW-1:0] TAIL_LAST = CW'(3);
    localparam logic [CW-1:0] PAIR_LAST = CW'(1);

    state_e        state, state_n;
    logic          is_rd, is_rd_n;
    logic          second, second_n;
    logic          seen, seen_n;
    logic [7:0]    sh, sh_n;
    logic [7:0]    stage, stage_n;
    logic [7:0]    rx_sh, rx_sh_n;
    logic [7:0]    rd_q, rd_q_n;
    logic          rseen_q, rseen_q_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          tmr_load, tmr_long, tmr_exp;
    logic          ack_s, rx_s;
    logic          clk_c, dat_c;

    pace_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .sel_long(tmr_long),
        .expired(tmr_exp)
    );

    in_sync #(.WIDTH(1), .RST_VAL(1'b1)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_n_i), .q(ack_s)
    );

    in_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_rx_sync (
        .clk(clk), .rst_n(rst_n), .d(rx_i), .q(rx_s)
    );

    // next-state and datapath decisions
    always_comb begin
        state_n   = state;
        is_rd_n   = is_rd;
        second_n  = second;
        seen_n    = seen;
        sh_n      = sh;
        stage_n   = stage;
        rx_sh_n   = rx_sh;
        rd_q_n    = rd_q;
        rseen_q_n = rseen_q;
        cnt_n     = cnt;
        tmr_load  = 1'b0;
        tmr_long  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid && (req_op != OP_NONE)) begin
                    tmr_load = 1'b1;
                    cnt_n    = '0;
                    seen_n   = 1'b0;
                    rx_sh_n  = '0;
                    is_rd_n  = (req_op == OP_READ);
                    second_n = (req_op == OP_WRITE);
                    sh_n     = build_cmd(req_addr, req_index, req_op == OP_WRITE);
                    stage_n  = req_wdata;
                    if (req_op == OP_RESET) begin
                        state_n = ST_RST_HI;
                    end else begin
                        state_n  = ST_START_LO;
                        tmr_long = 1'b1;
                    end
                end
            end
            ST_START_LO: if (tmr_exp) begin
                state_n = ST_START_HI; tmr_load = 1'b1;
            end
            ST_START_HI: if (tmr_exp) begin
                state_n = ST_BIT_LO; tmr_load = 1'b1; tmr_long = 1'b1; cnt_n = '0;
            end
            ST_BIT_LO: if (tmr_exp) begin
                state_n = ST_BIT_HI; tmr_load = 1'b1;
            end
            ST_BIT_HI: if (tmr_exp) begin
                tmr_load = 1'b1;
                tmr_long = 1'b1;
                sh_n     = {1'b0, sh[7:1]};
                if (cnt == BYTE_LAST) begin
                    cnt_n = '0;
                    if (second) begin
                        sh_n     = stage;
                        second_n = 1'b0;
                        state_n  = ST_START_LO;
                    end else if (is_rd) begin
                        state_n = ST_GAP_LO;
                    end else begin
                        state_n = ST_TRAIL_LO;
                    end
                end else begin
                    cnt_n   = cnt + 1'b1;
                    state_n = ST_BIT_LO;
                end
            end
            ST_TRAIL_LO: if (tmr_exp) begin
                state_n = ST_TRAIL_HI; tmr_load = 1'b1;
            end
            ST_TRAIL_HI: if (tmr_exp) begin
                if (cnt == PAIR_LAST) begin
                    state_n = ST_FINISH;
                end else begin
                    cnt_n = cnt + 1'b1; state_n = ST_TRAIL_LO;
                    tmr_load = 1'b1; tmr_long = 1'b1;
                end
            end
            ST_GAP_LO: if (tmr_exp) begin
                state_n = ST_POLL_HI; tmr_load = 1'b1; cnt_n = '0;
            end
            ST_POLL_HI: if (tmr_exp) begin
                state_n = ST_POLL_LO; tmr_load = 1'b1;
            end
            ST_POLL_LO: if (tmr_exp) begin
                tmr_load = 1'b1;
                if (!ack_s) begin
                    seen_n = 1'b1; cnt_n = '0; state_n = ST_RDAT_HI;
                end else if (cnt == POLL_LAST) begin
                    cnt_n = '0; state_n = ST_FILL_HI;
                end else begin
                    cnt_n = cnt + 1'b1; state_n = ST_POLL_HI;
                end
            end
            ST_RDAT_HI: if (tmr_exp) begin
                state_n = ST_RDAT_LO; tmr_load = 1'b1; tmr_long = 1'b1;
            end
            ST_RDAT_LO: if (tmr_exp) begin
                tmr_load = 1'b1;
                rx_sh_n  = {rx_s, rx_sh[7:1]};
                if (cnt == BYTE_LAST) begin
                    cnt_n = '0; state_n = ST_TAIL_HI;
                end else begin
                    cnt_n = cnt + 1'b1; state_n = ST_RDAT_HI;
                end
            end
            ST_FILL_HI: if (tmr_exp) begin
                state_n = ST_FILL_LO; tmr_load = 1'b1; tmr_long = 1'b1;
            end
            ST_FILL_LO: if (tmr_exp) begin
                tmr_load = 1'b1;
                if (cnt == PAIR_LAST) begin
                    cnt_n = '0; state_n = ST_TAIL_HI;
                end else begin
                    cnt_n = cnt + 1'b1; state_n = ST_FILL_HI;
                end
            end
            ST_TAIL_HI: if (tmr_exp) begin
                state_n = ST_TAIL_LO; tmr_load = 1'b1; tmr_long = 1'b1;
            end
            ST_TAIL_LO: if (tmr_exp) begin
                if (cnt == TAIL_LAST) begin
                    state_n   = ST_FINISH;
                    rd_q_n    = seen ? rx_sh : 8'h00;
                    rseen_q_n = seen;
                end else begin
                    cnt_n = cnt + 1'b1; state_n = ST_TAIL_HI; tmr_load = 1'b1;
                end
            end
            ST_RST_HI: if (tmr_exp) begin
                state_n = ST_RST_LO; tmr_load = 1'b1;
            end
            ST_RST_LO: if (tmr_exp) begin
                if (cnt == RST_LAST) begin
                    state_n = ST_FINISH;
                end else begin
                    cnt_n = cnt + 1'b1; state_n = ST_RST_HI; tmr_load = 1'b1;
                end
            end
            ST_FINISH: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            is_rd   <= 1'b0;
            second  <= 1'b0;
            seen    <= 1'b0;
            sh      <= '0;
            stage   <= '0;
            rx_sh   <= '0;
            rd_q    <= '0;
            rseen_q <= 1'b0;
            cnt     <= '0;
        end else begin
            state   <= state_n;
            is_rd   <= is_rd_n;
            second  <= second_n;
            seen    <= seen_n;
            sh      <= sh_n;
            stage   <= stage_n;
            rx_sh   <= rx_sh_n;
            rd_q    <= rd_q_n;
            rseen_q <= rseen_q_n;
            cnt     <= cnt_n;
        end
    end

    // line levels decoded from the state
    always_comb begin
        clk_c = 1'b0;
        dat_c = 1'b0;
        unique case (state)
            ST_START_LO:  begin clk_c = 1'b0; dat_c = 1'b1;  end
            ST_START_HI:  begin clk_c = 1'b1; dat_c = 1'b1;  end
            ST_BIT_LO:    begin clk_c = 1'b0; dat_c = sh[0]; end
            ST_BIT_HI:    begin clk_c = 1'b1; dat_c = sh[0]; end
            ST_TRAIL_HI:  begin clk_c = 1'b1; dat_c = 1'b0;  end
            ST_GAP_LO, ST_POLL_LO, ST_RDAT_LO, ST_FILL_LO:
                          begin clk_c = 1'b0; dat_c = 1'b1;  end
            ST_POLL_HI, ST_RDAT_HI, ST_FILL_HI:
                          begin clk_c = 1'b1; dat_c = 1'b1;  end
            ST_TAIL_HI:   begin clk_c = 1'b1; dat_c = (cnt == '0); end
            ST_RST_HI:    begin clk_c = 1'b1; dat_c = 1'b0;  end
            default:      begin clk_c = 1'b0; dat_c = 1'b0;  end
        endcase
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_o  <= 1'b0;
            sdata_o <= 1'b0;
        end else begin
            sclk_o  <= clk_c;
            sdata_o <= dat_c;
        end
    end

    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_FINISH);
    assign rd_data = rd_q;
    assign rd_seen = rseen_q;

    // assertions
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_idle_clock_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk_o && !sdata_o));
    assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op != OP_NONE) |=> busy);
    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_unused_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (!req_valid || req_op == OP_NONE)) |=> !busy);
    assert_data_stable_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));
    assert_poll_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL_HI || state == ST_POLL_LO) |-> (cnt <= POLL_LAST));
    assert_reset_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RST_HI || state == ST_RST_LO) |-> (cnt <= RST_LAST));
    assert_timeout_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_seen |-> (rd_data == 8'h00));

endmodule

// File: tb/xcvr_cfg_master_test.sv
module xcvr_cfg_master_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [6:0] req_addr = '0;
    logic [6:0] req_index = '0;
    logic [7:0] req_wdata = '0;
    logic       busy, done, rd_seen, sclk_o, sdata_o;
    logic [7:0] rd_data;
    logic       ack_n_i = 1'b1;
    logic       rx_i = 1'b0;

    int tests = 0;
    int fails = 0;
    int rise_cnt = 0;
    int done_cnt = 0;
    logic rec [0:63];
    bit   rd_mode = 0;
    int   resp_k = 0;
    logic [7:0] resp_byte = 8'h00;

    always #2.5 clk = ~clk;

    xcvr_cfg_master uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_index(req_index), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .rd_seen(rd_seen),
        .sclk_o(sclk_o), .sdata_o(sdata_o), .ack_n_i(ack_n_i), .rx_i(rx_i)
    );

    // record data at each rising clock edge and play the module's responses
    always @(posedge sclk_o) begin
        #1;
        rise_cnt = rise_cnt + 1;
        if (rise_cnt < 64) rec[rise_cnt] = sdata_o;
        if (rd_mode && resp_k != 0) begin
            if (rise_cnt == 9 + resp_k) ack_n_i = 1'b0;
            if (rise_cnt > 9 + resp_k && rise_cnt <= 17 + resp_k)
                rx_i = resp_byte[rise_cnt - 10 - resp_k];
        end
    end

    always @(posedge clk) if (done) done_cnt = done_cnt + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_req(input logic [1:0] op, input logic [6:0] a,
                            input logic [6:0] i, input logic [7:0] d);
        @(negedge clk);
        req_op = op; req_addr = a; req_index = i; req_wdata = d;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output bit got);
        int n = 0;
        got = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        got = done;
    endtask

    task automatic prep();
        @(negedge clk);
        rise_cnt = 0; ack_n_i = 1'b1; rx_i = 1'b0;
        for (int j = 0; j < 64; j++) rec[j] = 1'bx;
    endtask

    function automatic logic [7:0] cmd_of(input logic [6:0] a, input logic [6:0] i,
                                          input bit wr);
        return {1'b0, a} | {i, 1'b0} | {7'd0, wr};
    endfunction

    task automatic t_reset_state();
        chk(busy == 1'b0, "R9 reset busy", busy, 0);
        chk(done == 1'b0, "R9 reset done", done, 0);
        chk(sclk_o == 1'b0 && sdata_o == 1'b0, "R9 reset lines", {sclk_o, sdata_o}, 0);
        chk(rd_data == 8'h00 && rd_seen == 1'b0, "R9 reset rd_data", rd_data, 0);
    endtask

    task automatic t_write(input logic [6:0] a, input logic [6:0] i,
                           input logic [7:0] d, input bit widths);
        bit got;
        int hi_w = 0, lo_w = 0;
        logic [7:0] c = cmd_of(a, i, 1'b1);
        prep();
        fork
            send_req(2'b00, a, i, d);
            if (widths) begin
                @(posedge sclk_o);
                do begin @(posedge clk); #1; hi_w++; end while (sclk_o);
                do begin @(posedge clk); #1; lo_w++; end while (!sclk_o);
            end
        join
        wait_done(got);
        chk(got, "R9 write done", got, 1);
        chk(busy == 1'b1, "R9 busy with done", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0 && sclk_o == 1'b0, "R3 idle clock low", {busy, sclk_o}, 0);
        chk(rise_cnt == 20, "R3 write edges", rise_cnt, 20);
        chk(rec[1] == 1'b1 && rec[10] == 1'b1, "R2 start markers", {rec[1], rec[10]}, 3);
        for (int b = 0; b < 8; b++) begin
            chk(rec[2 + b] == c[b], "R1 command bit", rec[2 + b], c[b]);
            chk(rec[11 + b] == d[b], "R2 data bit lsb first", rec[11 + b], d[b]);
        end
        chk(rec[19] == 1'b0 && rec[20] == 1'b0, "R3 trailing low", {rec[19], rec[20]}, 0);
        if (widths) begin
            chk(hi_w == 8, "R11 high width", hi_w, 8);
            chk(lo_w == 20, "R11 bit low width", lo_w, 20);
        end
    endtask

    task automatic t_read(input logic [6:0] a, input logic [6:0] i,
                          input int k, input logic [7:0] byt);
        bit got;
        int p = (k != 0) ? k : 10;
        int total = 9 + p + ((k != 0) ? 8 : 2) + 4;
        logic [7:0] c = cmd_of(a, i, 1'b0);
        logic [7:0] exp_d = (k != 0) ? byt : 8'h00;
        prep();
        resp_k = k; resp_byte = byt; rd_mode = 1;
        send_req(2'b01, a, i, 8'hFF);
        wait_done(got);
        chk(got, "R5 read done", got, 1);
        chk(rd_data == exp_d, (k != 0) ? "R5 read data" : "R6 timeout data", rd_data, exp_d);
        chk(rd_seen == (k != 0), (k != 0) ? "R5 seen flag" : "R6 seen flag", rd_seen, k != 0);
        rd_mode = 0;
        @(negedge clk);
        chk(rise_cnt == total, (k != 0) ? "R7 read edges" : "R6 read edges", rise_cnt, total);
        for (int b = 0; b < 8; b++)
            chk(rec[2 + b] == c[b], "R1 read command bit", rec[2 + b], c[b]);
        for (int r = 10; r <= total - 4; r++)
            chk(rec[r] == 1'b1, "R4 poll data high", rec[r], 1);
        for (int r = total - 2; r <= total; r++)
            chk(rec[r] == 1'b0, "R7 tail data low", rec[r], 0);
        chk(sclk_o == 1'b0, "R7 clock ends low", sclk_o, 0);
    endtask

    task automatic t_burst();
        bit got;
        int ones = 0;
        prep();
        send_req(2'b10, 7'h00, 7'h00, 8'h00);
        wait_done(got);
        chk(got, "R8 burst done", got, 1);
        @(negedge clk);
        chk(rise_cnt == 30, "R8 burst edges", rise_cnt, 30);
        for (int r = 1; r <= 30; r++) if (rec[r] !== 1'b0) ones++;
        chk(ones == 0, "R8 data low", ones, 0);
        chk(sclk_o == 1'b0, "R8 clock ends low", sclk_o, 0);
    endtask

    task automatic t_busy_ignore();
        bit got;
        int d0;
        prep();
        d0 = done_cnt;
        send_req(2'b00, 7'h22, 7'h01, 8'h3C);
        repeat (100) @(negedge clk);
        send_req(2'b01, 7'h11, 7'h05, 8'h00);
        wait_done(got);
        repeat (300) @(negedge clk);
        chk(rise_cnt == 20, "R10 edges with late request", rise_cnt, 20);
        chk(done_cnt - d0 == 1, "R10 single done", done_cnt - d0, 1);
        chk(busy == 1'b0, "R10 no deferred start", busy, 0);
    endtask

    task automatic t_bad_op();
        int b = 0;
        prep();
        send_req(2'b11, 7'h7F, 7'h7F, 8'hFF);
        for (int n = 0; n < 50; n++) begin
            @(negedge clk);
            if (busy) b++;
        end
        chk(b == 0, "R10 unused op busy", b, 0);
        chk(rise_cnt == 0, "R10 unused op edges", rise_cnt, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset_state();
        t_write(7'h40, 7'h00, 8'h17, 1);
        t_write(7'h15, 7'h2A, 8'hA5, 0);
        t_read(7'h40, 7'h01, 3, 8'h5C);
        t_read(7'h33, 7'h02, 1, 8'h81);
        t_read(7'h08, 7'h07, 10, 8'hC3);
        t_read(7'h40, 7'h02, 0, 8'hEE);
        t_burst();
        t_busy_ignore();
        t_bad_op();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule